// File: doc/BRIEF.md
# Run-Time Programmable PRBS Test-Pattern Generator

This block produces pseudorandom test patterns from a 32-bit linear feedback shift register whose feedback polynomial is chosen at run time. A tap mask selects which register bits are XORed together to form the feedback bit. One block can therefore produce any polynomial up to degree 32 without a change to the logic. Each step shifts the register one place toward the MSB and inserts the feedback bit at bit 0. The feedback bit is also the generated data bit for that step.

The generated stream leaves on an 8-bit output in one of three forms: one bit, four bits or eight bits per enabled clock. An output format field selects the form, and an invert setting can flip the outbound data. The generator advances only on clocks where the transmit clock enable is high, so an external system can gap the clock. A small register-write port sets the tap mask, the output format and the invert setting.

Top module: `prbs_tap_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the register is loaded with all ones, the tap mask is set to the default (bits 30 and 27), the format is set to bit mode, inversion is turned off and `tx_data` is cleared to zero.
- R2: Each generator step computes fb = XOR of (register AND tap mask), shifts the register left by one with fb entering bit 0, and emits fb as the generated bit for that step.
- R3: Format code 2'b00 (bit mode) advances one step per enabled clock and drives the generated bit on `tx_data[0]`.
- R4: Format code 2'b01 (nibble mode) advances four steps per enabled clock and drives them on `tx_data[3:0]`, with the earliest bit on `tx_data[3]`.
- R5: Format codes 2'b10 and 2'b11 (byte mode) advance eight steps per enabled clock and drive them on `tx_data[7:0]`, with the earliest bit on `tx_data[7]`.
- R6: Output lines outside the active lanes of the current format are always driven low.
- R7: When inversion is on, every active output lane carries the complement of the generated bit. When inversion is off, the lanes carry the generated bits unchanged.
- R8: On a clock where `tx_clk_en` is low, both the register and `tx_data` hold their values.
- R9: If the register is all zeros on an enabled clock, it is loaded with all ones instead of stepping. The active lanes on that clock carry zeros before inversion.
- R10: A write to the tap mask reloads the register with all ones on that clock. No step is taken on that clock and `tx_data` holds, even if `tx_clk_en` is high.
- R11: Configuration writes use `cfg_addr`: 0 writes the tap mask (all 32 bits), 1 writes the format from `cfg_wdata[1:0]`, and 2 writes the invert setting from `cfg_wdata[0]`. Address 3 is ignored. A written value takes effect from the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| tx_clk_en | input | 1 | Transmit clock enable; low gaps the generator |
| tx_data | output | 8 | Registered pattern output |

## Verification
On every cycle, the assertions check the following: that the register and output hold through a gap, that a tap-mask write reseeds to all ones, that an all-zero register recovers to all ones, and that unused lanes stay low in the narrow formats. Only the bench scenarios can show that the bit sequence matches the programmed polynomial, and that the bit order across lanes is right in each format. The bench scenarios also cover the invert setting and the way lock-up recovery and mask rewrites fit into a running stream. The bench sweeps several tap masks across all four format codes and both invert settings, with a gapped enable pattern. It compares every output word against an arithmetic model of the register.

// File: rtl/prbs_pkg.sv
// Shared definitions for the programmable PRBS generator.
// Assumes: the output width is even so that nibble mode uses half of it.
package prbs_pkg;

    // Output format codes; both upper codes select the full width.
    typedef enum logic [1:0] {
        FMT_BIT      = 2'b00,
        FMT_NIB      = 2'b01,
        FMT_WIDE     = 2'b10,
        FMT_WIDE_ALT = 2'b11
    } fmt_e;

    // Configuration register addresses.
    localparam logic [1:0] ADDR_TAPS   = 2'd0;
    localparam logic [1:0] ADDR_FMT    = 2'd1;
    localparam logic [1:0] ADDR_INVERT = 2'd2;

endpackage

// File: rtl/prbs_cfg_regs.sv
// Configuration registers: tap mask, output format and invert setting.
// Assumes: one write per clock; a tap-mask write raises reseed in that
// same cycle so the register core can reload its seed.
module prbs_cfg_regs
    import prbs_pkg::*;
#(
    parameter int                LFSR_W   = 32,
    parameter logic [LFSR_W-1:0] DEF_TAPS = 32'h4800_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [LFSR_W-1:0] cfg_wdata,
    output logic [LFSR_W-1:0] tap_mask,
    output fmt_e              fmt,
    output logic              invert,
    output logic              reseed
);

    // Flag a tap-mask write so that the seed is reloaded on this clock.
    always_comb reseed = cfg_we && (cfg_addr == ADDR_TAPS);

    // Capture configuration writes; address 3 has no register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tap_mask <= DEF_TAPS;
            fmt      <= FMT_BIT;
            invert   <= 1'b0;
        end else if (cfg_we) begin
            case (cfg_addr)
                ADDR_TAPS:   tap_mask <= cfg_wdata;
                ADDR_FMT:    fmt      <= fmt_e'(cfg_wdata[1:0]);
                ADDR_INVERT: invert   <= cfg_wdata[0];
                default:     ;
            endcase
        end
    end

endmodule

// File: rtl/prbs_lfsr_core.sv
// Tap-masked shift register with a multi-step lookahead chain.
// Each step forms fb = ^(state & mask), shifts left and inserts fb.
// The chain computes MAX_STEPS steps in one clock. The format picks
// how many of them are committed. An all-zero state reloads all ones.
// Assumes: MAX_STEPS is even and at least 2.
module prbs_lfsr_core
    import prbs_pkg::*;
#(
    parameter int LFSR_W    = 32,
    parameter int MAX_STEPS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LFSR_W-1:0]    tap_mask,
    input  logic                 reseed,
    input  logic                 advance,
    input  fmt_e                 fmt,
    output logic [MAX_STEPS-1:0] step_bits,
    output logic                 lock_zero
);

    localparam int NIB_STEPS = MAX_STEPS / 2;

    logic [LFSR_W-1:0]                state_q;
    logic [MAX_STEPS:0][LFSR_W-1:0]   chain;
    logic [LFSR_W-1:0]                state_nxt;

    assign chain[0] = state_q;

    // Unroll one feedback step per stage of the lookahead chain.
    for (genvar k = 0; k < MAX_STEPS; k++) begin : g_step
        assign step_bits[k] = ^(chain[k] & tap_mask);
        assign chain[k+1]   = {chain[k][LFSR_W-2:0], step_bits[k]};
    end

    // Pick the state after the number of steps the format needs.
    always_comb begin
        case (fmt)
            FMT_BIT: state_nxt = chain[1];
            FMT_NIB: state_nxt = chain[NIB_STEPS];
            default: state_nxt = chain[MAX_STEPS];
        endcase
    end

    // Flag the lock-up state for recovery and for the formatter.
    always_comb lock_zero = (state_q == '0);

    // Update the register: seed, recovery from zero, or step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '1;
        end else if (reseed) begin
            state_q <= '1;
        end else if (advance) begin
            state_q <= lock_zero ? '1 : state_nxt;
        end
    end

    // R9
    lock_recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_zero && advance && !reseed) |=> (state_q == '1));

    // R10
    reseed_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reseed |=> (state_q == '1));

    // R8
    gap_state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !reseed) |=> $stable(state_q));

endmodule

// File: rtl/prbs_out_fmt.sv
// Output formatter: orders the generated bits onto the output lanes,
// applies inversion, clears unused lanes and registers the word.
// Assumes: step_bits[0] is the earliest generated bit; OUT_W is even.
module prbs_out_fmt
    import prbs_pkg::*;
#(
    parameter int OUT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic             reseed,
    input  fmt_e             fmt,
    input  logic             invert,
    input  logic             lock_zero,
    input  logic [OUT_W-1:0] step_bits,
    output logic [OUT_W-1:0] tx_data
);

    localparam int NIB_W = OUT_W / 2;

    logic [OUT_W-1:0] wide_word;
    logic [OUT_W-1:0] nib_word;
    logic [OUT_W-1:0] bit_word;
    logic [OUT_W-1:0] raw_word;
    logic [OUT_W-1:0] lane_mask;
    logic [OUT_W-1:0] word_nxt;

    // Reverse the step order so that the earliest bit sits on the top lane.
    for (genvar i = 0; i < OUT_W; i++) begin : g_lane
        assign wide_word[i] = step_bits[OUT_W-1-i];
        if (i < NIB_W) begin : g_nib
            assign nib_word[i] = step_bits[NIB_W-1-i];
        end else begin : g_nib_off
            assign nib_word[i] = 1'b0;
        end
    end

    assign bit_word = {{(OUT_W-1){1'b0}}, step_bits[0]};

    // Select lanes and data for the current format.
    always_comb begin
        case (fmt)
            FMT_BIT: begin
                raw_word  = bit_word;
                lane_mask = {{(OUT_W-1){1'b0}}, 1'b1};
            end
            FMT_NIB: begin
                raw_word  = nib_word;
                lane_mask = {{NIB_W{1'b0}}, {NIB_W{1'b1}}};
            end
            default: begin
                raw_word  = wide_word;
                lane_mask = '1;
            end
        endcase
    end

    // Blank data on lock-up, invert if asked, then clear idle lanes.
    always_comb begin
        word_nxt = (lock_zero ? '0 : raw_word) ^ {OUT_W{invert}};
        word_nxt = word_nxt & lane_mask;
    end

    // Register the output word on enabled clocks that are not reseeding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_data <= '0;
        end else if (advance && !reseed) begin
            tx_data <= word_nxt;
        end
    end

    // R8
    gap_out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(tx_data));

    // R10
    reseed_out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reseed |=> $stable(tx_data));

    // R6
    bit_lanes_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !reseed && fmt == FMT_BIT) |=> (tx_data[OUT_W-1:1] == '0));

    // R6
    nib_lanes_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !reseed && fmt == FMT_NIB) |=> (tx_data[OUT_W-1:NIB_W] == '0));

endmodule

// File: rtl/prbs_tap_gen.sv
// Top of the programmable PRBS generator: configuration registers,
// the tap-masked shift-register core and the output formatter.
// Assumes: tx_clk_en is synchronous to clk; reset is synchronous.
module prbs_tap_gen
    import prbs_pkg::*;
#(
    parameter int                LFSR_W   = 32,
    parameter int                OUT_W    = 8,
    parameter logic [LFSR_W-1:0] DEF_TAPS = 32'h4800_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [LFSR_W-1:0] cfg_wdata,
    input  logic              tx_clk_en,
    output logic [OUT_W-1:0]  tx_data
);

    logic [LFSR_W-1:0] tap_mask;
    fmt_e              fmt;
    logic              invert;
    logic              reseed;
    logic [OUT_W-1:0]  step_bits;
    logic              lock_zero;

    prbs_cfg_regs #(
        .LFSR_W   (LFSR_W),
        .DEF_TAPS (DEF_TAPS)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .tap_mask  (tap_mask),
        .fmt       (fmt),
        .invert    (invert),
        .reseed    (reseed)
    );

    prbs_lfsr_core #(
        .LFSR_W    (LFSR_W),
        .MAX_STEPS (OUT_W)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tap_mask  (tap_mask),
        .reseed    (reseed),
        .advance   (tx_clk_en),
        .fmt       (fmt),
        .step_bits (step_bits),
        .lock_zero (lock_zero)
    );

    prbs_out_fmt #(
        .OUT_W (OUT_W)
    ) u_fmt (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (tx_clk_en),
        .reseed    (reseed),
        .fmt       (fmt),
        .invert    (invert),
        .lock_zero (lock_zero),
        .step_bits (step_bits),
        .tx_data   (tx_data)
    );

endmodule

// File: tb/prbs_tap_gen_tb.sv
`timescale 1ns/1ps
module prbs_tap_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic        tx_clk_en = 1'b0;
    logic [7:0]  tx_data;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    // Arithmetic model of the register and settings.
    logic [31:0] m_state;
    logic [31:0] m_mask;
    logic [1:0]  m_fmt;
    logic        m_inv;
    logic [7:0]  m_out;

    always #4 clk = ~clk;

    prbs_tap_gen u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .tx_clk_en (tx_clk_en),
        .tx_data   (tx_data)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: tx_data=%02h expected=%02h", req, got, exp);
        end
    endtask

    // Model one enabled clock.
    task automatic model_advance();
        int n;
        logic [7:0] bits;
        logic [7:0] lanes;
        logic fb;
        n = (m_fmt == 2'b00) ? 1 : (m_fmt == 2'b01) ? 4 : 8;
        lanes = (n == 1) ? 8'h01 : (n == 4) ? 8'h0F : 8'hFF;
        bits = '0;
        if (m_state == 32'h0) begin
            m_state = 32'hFFFF_FFFF;
        end else begin
            for (int k = 0; k < n; k++) begin
                fb = ^(m_state & m_mask);
                m_state = {m_state[30:0], fb};
                bits[n-1-k] = fb;
            end
        end
        m_out = (bits ^ {8{m_inv}}) & lanes;
    endtask

    // Apply one clock with the given enable; optional config write.
    task automatic tick(input logic en, input logic we, input logic [1:0] a,
                        input logic [31:0] d, input string req);
        tx_clk_en = en;
        cfg_we    = we;
        cfg_addr  = a;
        cfg_wdata = d;
        @(posedge clk);
        if (we && a == 2'd0) begin
            m_state = 32'hFFFF_FFFF;
        end else if (en) begin
            model_advance();
        end
        if (we) begin
            case (a)
                2'd0: m_mask = d;
                2'd1: m_fmt  = d[1:0];
                2'd2: m_inv  = d[0];
                default: ;
            endcase
        end
        @(negedge clk);
        cfg_we = 1'b0;
        check(req, tx_data, m_out);
    endtask

    task automatic run(input int cnt, input string req);
        for (int i = 0; i < cnt; i++) begin
            tick((i % 5) != 3, 1'b0, 2'd0, 32'h0, (i % 5) == 3 ? "R8" : req);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] masks [4];
        string tag;
        masks[0] = 32'h4800_0000;
        masks[1] = 32'h8000_0001;
        masks[2] = 32'hFFFF_FFFF;
        masks[3] = 32'h0060_0000;

        // R1: reset state
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_state = 32'hFFFF_FFFF;
        m_mask  = 32'h4800_0000;
        m_fmt   = 2'b00;
        m_inv   = 1'b0;
        m_out   = 8'h00;
        check("R1", tx_data, 8'h00);
        // R1: default taps and bit mode from the reset state
        for (int i = 0; i < 40; i++) tick(1'b1, 1'b0, 2'd0, 32'h0, "R1");

        // R2 R3 R4 R5 R7: sweep masks, formats and inversion
        for (int mi = 0; mi < 4; mi++) begin
            for (int f = 0; f < 4; f++) begin
                for (int v = 0; v < 2; v++) begin
                    tick(1'b0, 1'b1, 2'd0, masks[mi], "R10");
                    tick(1'b0, 1'b1, 2'd1, 32'(f), "R11");
                    tick(1'b0, 1'b1, 2'd2, 32'(v), "R11");
                    tag = (v == 1) ? "R7" : (f == 0) ? "R3" : (f == 1) ? "R4" : "R5";
                    run(40, tag);
                    // R2: steady run with no gaps
                    for (int i = 0; i < 8; i++) tick(1'b1, 1'b0, 2'd0, 32'h0, "R2");
                end
            end
        end

        // R6: idle lanes in narrow formats
        tick(1'b0, 1'b1, 2'd2, 32'h1, "R11");
        tick(1'b0, 1'b1, 2'd1, 32'h0, "R11");
        for (int i = 0; i < 10; i++) begin
            tick(1'b1, 1'b0, 2'd0, 32'h0, "R6");
            check("R6", {tx_data[7:1], 1'b0}, 8'h00);
        end
        tick(1'b0, 1'b1, 2'd1, 32'h1, "R11");
        for (int i = 0; i < 10; i++) begin
            tick(1'b1, 1'b0, 2'd0, 32'h0, "R6");
            check("R6", {tx_data[7:4], 4'h0}, 8'h00);
        end

        // R9: zero mask drains the register, then it recovers
        tick(1'b0, 1'b1, 2'd2, 32'h0, "R11");
        tick(1'b0, 1'b1, 2'd0, 32'h0, "R9");
        tick(1'b0, 1'b1, 2'd1, 32'h2, "R9");
        for (int i = 0; i < 12; i++) tick(1'b1, 1'b0, 2'd0, 32'h0, "R9");
        tick(1'b0, 1'b1, 2'd1, 32'h0, "R9");
        for (int i = 0; i < 70; i++) tick(1'b1, 1'b0, 2'd0, 32'h0, "R9");

        // R10: mask write with the enable high takes no step
        tick(1'b0, 1'b1, 2'd1, 32'h2, "R11");
        tick(1'b1, 1'b1, 2'd0, 32'h4800_0000, "R10");
        for (int i = 0; i < 3; i++) tick(1'b1, 1'b0, 2'd0, 32'h0, "R10");
        tick(1'b1, 1'b1, 2'd0, 32'h8000_0001, "R10");
        for (int i = 0; i < 3; i++) tick(1'b1, 1'b0, 2'd0, 32'h0, "R10");

        // R11: address 3 is ignored, stream continues unchanged
        tick(1'b1, 1'b1, 2'd3, 32'hFFFF_FFFF, "R11");
        for (int i = 0; i < 8; i++) tick(1'b1, 1'b0, 2'd0, 32'h0, "R11");

        // R8: long gap holds the output
        for (int i = 0; i < 6; i++) tick(1'b0, 1'b0, 2'd0, 32'h0, "R8");
        tick(1'b1, 1'b0, 2'd0, 32'h0, "R8");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule